// File: doc/BRIEF.md
# Rounded Divider Ratio Planner

This block turns a pair of unsigned rates (the clock feeding a channel and the rate wanted at its output) into settings for two cascaded clock dividers. It finds the division ratio rounded to the nearest integer, using the remainder of a multi-cycle restoring division. It then places that ratio in one of the two dividers. Small ratios go to the narrow final divider. Large ratios go to the wide pre-divider, with the other divider set to pass the clock straight through.

A host pulses `start` with the operands held on the inputs. It waits for the single-cycle `done` pulse, then reads the two field values. Each field value is the divide factor minus one. The host also reads a flag that says whether the output synchroniser must be switched off before the fields are written. The block only plans the settings; writing them into channel registers is left to the host.

Top module: `rdp_ratio_planner`

## Requirements
- R1: After reset, `busy`, `done`, `sync_clear`, `err_zero` and `err_range` are 0 and both field outputs are 0.
- R2: For a non-zero requested rate Q and parent rate P, the ratio is floor(P/Q), plus one unless Q > 2*(P mod Q).
- R3: When the ratio is between 1 and 64, `pre_field` is 0 and `fin_field` is the ratio minus 1, with `err_range` 0.
- R4: When the ratio is between 65 and 1024, `fin_field` is 0 and `pre_field` is the ratio minus 1, with `err_range` 0.
- R5: When the ratio exceeds 1024, `fin_field` is 0, `pre_field` is 1023 (all ones) and `err_range` is 1.
- R6: When the rounded ratio is 0, it is raised to 1: both fields are 0 and `err_range` is 1.
- R7: A requested rate of 0 gives `err_zero` = 1, `err_range` = 0 and `sync_clear` = 0, and both fields keep their previous values.
- R8: On a non-zero request, `sync_clear` equals the `sync_mode` input sampled with `start`.
- R9: `done` is high for exactly one cycle per accepted start. Fields and flags change only in that cycle and hold until the next `done`.
- R10: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. A `start` seen while busy is ignored, and so are operand changes made while busy.
- R11: `done` rises RATE_W+1 clock edges after the edge that samples `start` for a non-zero requested rate, and 1 edge after it for a zero requested rate.
- R12: A `start` presented in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted while idle |
| sync_mode | input | 1 | Channel uses the output synchroniser, sampled with start |
| parent_rate | input | RATE_W | Rate of the clock feeding the channel |
| req_rate | input | RATE_W | Wanted output rate |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result pulse |
| pre_field | output | PDIV_W | Pre-divider field (factor minus one) |
| fin_field | output | FDIV_W | Final divider field (factor minus one) |
| sync_clear | output | 1 | Host must disable the synchroniser before writing |
| err_zero | output | 1 | Requested rate was zero, fields unchanged |
| err_range | output | 1 | Ratio was clamped to the reachable range |

## Verification
The two functions that meet in one cycle are result delivery and request acceptance: a `start` driven while `done` is high must begin a new division and leave the delivered result intact. The bench issues every sweep request in the `done` cycle of the previous one, so each of roughly 1600 operations hits this case. Each result is compared with the rounded split computed arithmetically, and the latency is counted to the edge. A second case places a `start` with new operands in the middle of a running division; the result must match the first operands only.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } rdp_state_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/rdp_divider.sv
// Restoring divider: one quotient bit per step, operands latched on load.
module rdp_divider #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [RATE_W-1:0] dividend,
  input  logic [RATE_W-1:0] divisor,
  output logic [RATE_W-1:0] quo,
  output logic [RATE_W-1:0] rem,
  output logic [RATE_W-1:0] den
);
  logic [RATE_W-1:0] quo_q, quo_d;
  logic [RATE_W-1:0] rem_q, rem_d;
  logic [RATE_W-1:0] den_q, den_d;
  logic [RATE_W:0]   rem_sh;
  logic [RATE_W:0]   diff;
  logic              fits;
  logic              en;

  always_comb begin
    rem_sh = {rem_q, quo_q[RATE_W-1]};
    diff   = rem_sh - {1'b0, den_q};
    fits   = (rem_sh >= {1'b0, den_q});
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    en     = load | step;
    if (load) begin
      quo_d = dividend;
      rem_d = '0;
      den_d = divisor;
    end else if (step) begin
      quo_d = {quo_q[RATE_W-2:0], fits};
      rem_d = fits ? diff[RATE_W-1:0] : rem_sh[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      den_q <= den_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
  assign den = den_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && den_q != '0) |=> (rem_q < den_q)); // R2
endmodule

// File: rtl/rdp_split.sv
// Rounds the quotient to nearest and steers it to one of the two dividers.
module rdp_split #(
  parameter int RATE_W = 32,
  parameter int FDIV_W = 6,
  parameter int PDIV_W = 10
) (
  input  logic [RATE_W-1:0] quo_i,
  input  logic [RATE_W-1:0] rem_i,
  input  logic [RATE_W-1:0] den_i,
  output logic [PDIV_W-1:0] pre_o,
  output logic [FDIV_W-1:0] fin_o,
  output logic              range_o
);
  localparam int RATIO_W = RATE_W + 1;
  localparam int FIN_LIM = 1 << FDIV_W;
  localparam int PRE_LIM = 1 << PDIV_W;
  localparam int CMP_W   = (RATIO_W > PDIV_W + 1) ? RATIO_W : PDIV_W + 1;

  logic [RATIO_W-1:0] twice_rem;
  logic [RATIO_W-1:0] ratio;
  logic               bump;
  logic [CMP_W-1:0]   ratio_x;
  logic [CMP_W-1:0]   ratio_c;
  logic [CMP_W-1:0]   minus1;
  logic               under;
  logic               over;
  logic               use_fin;

  always_comb begin
    twice_rem = {rem_i, 1'b0};
    bump      = !({1'b0, den_i} > twice_rem);
    ratio     = {1'b0, quo_i} + RATIO_W'(bump);
    ratio_x   = CMP_W'(ratio);
    under     = (ratio_x == '0);
    ratio_c   = under ? CMP_W'(1) : ratio_x;
    minus1    = ratio_c - CMP_W'(1);
    over      = (ratio_c > CMP_W'(PRE_LIM));
    use_fin   = (ratio_c <= CMP_W'(FIN_LIM));
    fin_o     = use_fin ? FDIV_W'(minus1) : '0;
    if (use_fin)   pre_o = '0;
    else if (over) pre_o = '1;
    else           pre_o = PDIV_W'(minus1);
    range_o   = under | over;
  end
endmodule

// File: rtl/rdp_ratio_planner.sv
module rdp_ratio_planner
  import rdp_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int FDIV_W = 6,
  parameter int PDIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sync_mode,
  input  logic [RATE_W-1:0] parent_rate,
  input  logic [RATE_W-1:0] req_rate,
  output logic              busy,
  output logic              done,
  output logic [PDIV_W-1:0] pre_field,
  output logic [FDIV_W-1:0] fin_field,
  output logic              sync_clear,
  output logic              err_zero,
  output logic              err_range
);
  localparam int CNT_W = (RATE_W > 2) ? $clog2(RATE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE_W - 1);

  logic rst_q_n;

  rdp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  rdp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic             zero_q, zero_d;
  logic             div_load, div_step;
  logic             done_q, done_d;
  logic             out_en;

  logic [RATE_W-1:0] dv_quo, dv_rem, dv_den;
  logic [PDIV_W-1:0] sp_pre;
  logic [FDIV_W-1:0] sp_fin;
  logic              sp_range;

  logic [PDIV_W-1:0] pre_q, pre_d;
  logic [FDIV_W-1:0] fin_q, fin_d;
  logic              sync_q, sync_d;
  logic              ez_q, ez_d;
  logic              er_q, er_d;

  rdp_divider #(.RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (div_load),
    .step     (div_step),
    .dividend (parent_rate),
    .divisor  (req_rate),
    .quo      (dv_quo),
    .rem      (dv_rem),
    .den      (dv_den)
  );

  rdp_split #(.RATE_W(RATE_W), .FDIV_W(FDIV_W), .PDIV_W(PDIV_W)) u_split (
    .quo_i   (dv_quo),
    .rem_i   (dv_rem),
    .den_i   (dv_den),
    .pre_o   (sp_pre),
    .fin_o   (sp_fin),
    .range_o (sp_range)
  );

  // Sequencer next state
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    zero_d   = zero_q;
    div_load = 1'b0;
    div_step = 1'b0;
    done_d   = 1'b0;
    out_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d = sync_mode;
          cnt_d  = '0;
          if (req_rate == '0) begin
            zero_d  = 1'b1;
            state_d = ST_FIN;
          end else begin
            zero_d   = 1'b0;
            div_load = 1'b1;
            state_d  = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        div_step = 1'b1;
        cnt_d    = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        done_d  = 1'b1;
        out_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Result next values, applied only on the finishing edge
  always_comb begin
    pre_d  = zero_q ? pre_q : sp_pre;
    fin_d  = zero_q ? fin_q : sp_fin;
    sync_d = !zero_q && mode_q;
    ez_d   = zero_q;
    er_d   = !zero_q && sp_range;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      zero_q  <= zero_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pre_q  <= '0;
      fin_q  <= '0;
      sync_q <= 1'b0;
      ez_q   <= 1'b0;
      er_q   <= 1'b0;
    end else if (out_en) begin
      pre_q  <= pre_d;
      fin_q  <= fin_d;
      sync_q <= sync_d;
      ez_q   <= ez_d;
      er_q   <= er_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign pre_field  = pre_q;
  assign fin_field  = fin_q;
  assign sync_clear = sync_q;
  assign err_zero   = ez_q;
  assign err_range  = er_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done); // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !done |-> ($stable(pre_field) && $stable(fin_field) && $stable(err_range))); // R9
  AST_ONE_DIVIDER: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && !err_zero) |-> (pre_field == '0 || fin_field == '0)); // R3
  AST_ZERO_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && err_zero) |-> (!sync_clear && !err_range)); // R7
  AST_CLAMP_FINAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && err_range && pre_field != '0) |-> (fin_field == '0 && pre_field == '1)); // R5
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> done); // R10
endmodule

// File: tb/sim_rdp_ratio_planner.sv
module sim_rdp_ratio_planner;
  localparam int RW = 12;
  localparam int FW = 6;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sync_mode = 1'b0;
  logic [RW-1:0] parent_rate = '0;
  logic [RW-1:0] req_rate = '0;
  logic          busy, done, sync_clear, err_zero, err_range;
  logic [PW-1:0] pre_field;
  logic [FW-1:0] fin_field;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rdp_ratio_planner #(.RATE_W(RW), .FDIV_W(FW), .PDIV_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_mode(sync_mode),
    .parent_rate(parent_rate), .req_rate(req_rate), .busy(busy), .done(done),
    .pre_field(pre_field), .fin_field(fin_field), .sync_clear(sync_clear),
    .err_zero(err_zero), .err_range(err_range)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d cycles exp<150000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Arithmetic model of the rounded split
  task automatic model(input int p, input int q, output int epre, output int efin,
                       output int eer, output string tag);
    int r, rat;
    rat = p / q;
    r   = p % q;
    if (!(q > 2 * r)) rat = rat + 1;   // R2 rounding
    eer = 0;
    if (rat == 0) begin rat = 1; eer = 1; tag = "R6"; end
    else if (rat <= 64) tag = "R3";
    else if (rat <= 1024) tag = "R4";
    else tag = "R5";
    if (rat <= 64) begin epre = 0; efin = rat - 1; end
    else if (rat <= 1024) begin efin = 0; epre = rat - 1; end
    else begin efin = 0; epre = 1023; eer = 1; end
  endtask

  // Drives start at a negedge and returns at the negedge where done is seen
  task automatic run_op(input int p, input int q, input bit sm);
    int lat, epre, efin, eer, prev_pre, prev_fin;
    string tag;
    prev_pre    = pre_field;
    prev_fin    = fin_field;
    parent_rate = RW'(p);
    req_rate    = RW'(q);
    sync_mode   = sm;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R10 busy after start", busy, 1);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 latency", lat, (q == 0) ? 1 : RW + 1);
    if (q == 0) begin
      chk("R7 err_zero", err_zero, 1);
      chk("R7 err_range", err_range, 0);
      chk("R7 sync_clear", sync_clear, 0);
      chk("R7 pre kept", pre_field, prev_pre);
      chk("R7 fin kept", fin_field, prev_fin);
    end else begin
      model(p, q, epre, efin, eer, tag);
      chk({tag, " R2 pre_field"}, pre_field, epre);
      chk({tag, " R2 fin_field"}, fin_field, efin);
      chk({tag, " err_range"}, err_range, eer);
      chk("R8 sync_clear", sync_clear, sm);
      chk("R7 err_zero clear", err_zero, 0);
    end
    chk("R10 busy low at done", busy, 0);
  endtask

  initial begin
    int hp, hf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 pre", pre_field, 0);
    chk("R1 fin", fin_field, 0);
    chk("R1 flags", {sync_clear, err_zero, err_range}, 0);

    // Boundary cases
    run_op(64, 1, 1);     // R3 largest final ratio
    run_op(65, 1, 0);     // R4 smallest pre ratio
    run_op(1024, 1, 1);   // R4 top of pre range
    run_op(1025, 1, 0);   // R5 clamp
    run_op(4095, 1, 1);   // R5
    run_op(1, 4095, 0);   // R6 ratio rounds to zero
    run_op(5, 2, 1);      // R2 half rounds up
    run_op(7, 4, 0);      // R2
    run_op(130, 2, 1);    // R4
    run_op(500, 0, 1);    // R7 fields kept from previous op

    // R9 hold: no pulse and no change while idle
    hp = pre_field;
    hf = fin_field;
    repeat (3) @(negedge clk);
    chk("R9 done single", done, 0);
    chk("R9 pre held", pre_field, hp);
    chk("R9 fin held", fin_field, hf);

    // R10 start and operand changes while busy are ignored
    parent_rate = RW'(1000);
    req_rate    = RW'(3);
    sync_mode   = 1'b0;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    parent_rate = RW'(5);
    req_rate    = RW'(1);
    sync_mode   = 1'b1;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 ignored start pre", pre_field, 332);
    chk("R10 ignored start fin", fin_field, 0);
    chk("R10 ignored sync", sync_clear, 0);

    // R12 sweep: every request is issued in the done cycle of the last one
    for (int q = 0; q < 40; q++) begin
      for (int k = 0; k < 40; k++) begin
        run_op((k * 105 + q * 7) % 4096, q, k[0]);
        chk("R12 done seen", done, 1);
      end
    end
    @(negedge clk);
    chk("R9 done dropped", done, 0);
    report();
  end
endmodule